// File: doc/BRIEF.md
# Reset and Boot Mode Sequencer

This block steers a graphics processor from an active-low reset to its first instruction fetch. While reset is held it keeps every output at zero. It samples the host chip-select level on the final clock edge of reset to pick a start mode. Host-present mode is selected when that level is high, and self-bootstrap mode when it is low.

In both modes it first issues a burst of DRAM initialization cycles through a request/acknowledge handshake with the memory controller. Periodic refresh then continues for as long as the block is out of reset. In host-present mode it opens host memory access and waits until the host writes zero to the halt bit of its control word. In self-bootstrap mode it goes straight on. It then requests a read of the level-0 reset vector and, once that read is acknowledged, signals that execution may begin.

The current phase is visible on a status output. The state codes are 0 for reset, 1 for the initialization burst, 2 for halted, 3 for the vector fetch and 4 for run.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst_n` is low, `ref_req`, `vec_req`, `host_acc_ok` and `exec_go` are 0, `vec_addr` is 0 and `boot_state` is 0.
- R2: The mode is the `host_sel` level seen on the last rising clock edge at which `rst_n` is low: 1 selects host-present mode and 0 selects self-bootstrap mode. Levels on earlier reset edges and after release have no effect.
- R3: On the first edge after release the state becomes 1. `ref_req` then stays high until exactly `N_INIT` (default 8) edges with `ref_ack` high have occurred, and only acknowledged cycles count.
- R4: `host_acc_ok` is 1 only in host-present mode, from the edge of the last initialization acknowledge onward, and it stays 0 throughout in self-bootstrap mode.
- R5: In host-present mode the block enters state 2 after the burst and raises no `vec_req` there. A `ctl_we` write with bit `HALT_BIT` (default 15) of `ctl_wdata` at 0 clears the halt, and a write with that bit at 1 has no effect.
- R6: A clearing write made during the burst is remembered, so that host-present mode goes from state 1 directly to state 3.
- R7: Once the burst has ended, `ref_req` rises `REF_INTERVAL` clock edges after the edge of the last initialization acknowledge or of the last refresh acknowledge, and it holds until it is acknowledged. This applies in states 2, 3 and 4.
- R8: In state 3, `vec_req` is high with `vec_addr` = FFFFFFE0h, except while a refresh is pending, when `vec_req` is low. An edge with both `vec_req` and `vec_ack` high moves the block to state 4, where `exec_go` is 1.
- R9: In self-bootstrap mode the block goes from state 1 directly to state 3 at the last initialization acknowledge.
- R10: Driving `rst_n` low in any state returns the block at once to state 0 with all outputs at their R1 values, and the next release repeats the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| host_sel | input | 1 | Host chip-select level, sampled during reset |
| ctl_we | input | 1 | Host control-word write strobe |
| ctl_wdata | input | CTL_W | Host control-word write data; bit HALT_BIT is the halt bit |
| ref_req | output | 1 | DRAM initialization or refresh cycle request |
| ref_ack | input | 1 | Memory controller acknowledge of one refresh cycle |
| host_acc_ok | output | 1 | Host memory access allowed |
| vec_req | output | 1 | Reset-vector read request |
| vec_ack | input | 1 | Memory controller acknowledge of the vector read |
| vec_addr | output | ADDR_W | Vector address, valid with vec_req |
| exec_go | output | 1 | Instruction execution may begin |
| boot_state | output | 3 | Current phase code |

## Verification
The refresh timer can expire in the same cycle in which the vector fetch is being requested. When that happens the fetch request must drop until the refresh is acknowledged. The bench provokes this in self-bootstrap mode by withholding `vec_ack`, so that the block stays in the fetch state until the timer fires. It then checks that `vec_req` is low while `ref_req` is high, and that the fetch resumes and completes after the refresh acknowledge. A second collision occurs when the halt-clearing write lands during the burst. In that case the bench checks that the block never visits the halted state.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    BS_RESET = 3'd0,
    BS_INIT  = 3'd1,
    BS_HALT  = 3'd2,
    BS_FETCH = 3'd3,
    BS_RUN   = 3'd4
  } boot_state_e;

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch #(
  parameter int CTL_W    = 16,
  parameter int HALT_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel_i,
  input  logic             start_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic             mode_host_o,
  output logic             halt_eff_o
);

  logic smp_q;
  logic mode_q, mode_d;
  logic halt_q, halt_d;
  logic clr;

  // Sample the chip-select level only while reset is held: the last value stays.
  always_ff @(posedge clk) begin
    if (!rst_n) smp_q <= host_sel_i;
  end

  assign clr = ctl_we_i & ~ctl_wdata_i[HALT_BIT];

  always_comb begin
    mode_d = mode_q;
    halt_d = halt_q & ~clr;
    if (start_i) begin
      mode_d = smp_q;
      halt_d = smp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      halt_q <= halt_d;
    end
  end

  assign mode_host_o = mode_q;
  assign halt_eff_o  = halt_q & ~clr;

endmodule

// File: rtl/boot_init_ctr.sv
module boot_init_ctr #(
  parameter int N_INIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic last_o
);

  localparam int CW = $clog2(N_INIT + 1);
  localparam logic [CW-1:0] LAST = CW'(N_INIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/boot_ref_timer.sv
module boot_ref_timer #(
  parameter int INTERVAL = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic load_i,
  output logic pend_o
);

  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;

  always_comb begin
    tmr_d  = tmr_q;
    pend_d = pend_q;
    if (load_i) begin
      tmr_d  = RELOAD;
      pend_d = 1'b0;
    end else if (run_i && !pend_q) begin
      if (tmr_q == '0) pend_d = 1'b1;
      else             tmr_d  = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_pkg::*;
#(
  parameter int              N_INIT       = 8,
  parameter int              REF_INTERVAL = 32,
  parameter int              CTL_W        = 16,
  parameter int              HALT_BIT     = 15,
  parameter int              ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 32'hFFFF_FFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              ref_req,
  input  logic              ref_ack,
  output logic              host_acc_ok,
  output logic              vec_req,
  input  logic              vec_ack,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              exec_go,
  output logic [2:0]        boot_state
);

  boot_state_e state_q, state_d;

  logic start, mode_host, halt_eff;
  logic init_step, init_last, init_done;
  logic post_init, ref_pend, ref_load, vec_fire;

  assign start     = (state_q == BS_RESET);
  assign init_step = (state_q == BS_INIT) & ref_ack;
  assign init_done = init_step & init_last;
  assign post_init = (state_q == BS_HALT) | (state_q == BS_FETCH) | (state_q == BS_RUN);
  assign ref_load  = init_done | (ref_pend & ref_ack);
  assign vec_fire  = vec_req & vec_ack;

  boot_mode_latch #(.CTL_W(CTL_W), .HALT_BIT(HALT_BIT)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel_i  (host_sel),
    .start_i     (start),
    .ctl_we_i    (ctl_we),
    .ctl_wdata_i (ctl_wdata),
    .mode_host_o (mode_host),
    .halt_eff_o  (halt_eff)
  );

  boot_init_ctr #(.N_INIT(N_INIT)) u_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (init_step),
    .last_o (init_last)
  );

  boot_ref_timer #(.INTERVAL(REF_INTERVAL)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (post_init),
    .load_i (ref_load),
    .pend_o (ref_pend)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_RESET: state_d = BS_INIT;
      BS_INIT:  if (init_done) state_d = (mode_host && halt_eff) ? BS_HALT : BS_FETCH;
      BS_HALT:  if (!halt_eff) state_d = BS_FETCH;
      BS_FETCH: if (vec_fire)  state_d = BS_RUN;
      BS_RUN:   state_d = BS_RUN;
      default:  state_d = BS_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BS_RESET;
    else        state_q <= state_d;
  end

  assign ref_req     = (state_q == BS_INIT) | ref_pend;
  assign vec_req     = (state_q == BS_FETCH) & ~ref_pend;
  assign vec_addr    = vec_req ? VEC_ADDR : '0;
  assign host_acc_ok = mode_host & post_init;
  assign exec_go     = (state_q == BS_RUN);
  assign boot_state  = state_q;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 32'hFFFF_FFE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              host_acc_ok,
  input logic              vec_req,
  input logic              vec_ack,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              exec_go,
  input logic [2:0]        boot_state
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!ref_req && !vec_req && !host_acc_ok && !exec_go &&
                                   vec_addr == '0 && boot_state == 3'd0)
        else $error("R1 outputs not quiet in reset");
    end
  end

  a_r3_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_ack |=> ref_req)
    else $error("R3/R7 refresh request dropped before acknowledge");

  a_r4_acc_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_acc_ok) |-> $past(ref_req && ref_ack))
    else $error("R4 host access opened without burst end");

  a_r5_no_fetch_halted: assert property (@(posedge clk) disable iff (!rst_n)
    boot_state == 3'd2 |-> !vec_req)
    else $error("R5 vector request while halted");

  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !ref_req)
    else $error("R8 vector request during pending refresh");

  a_r8_vec_addr: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> vec_addr == VEC_ADDR)
    else $error("R8 wrong vector address");

  a_r8_run_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_go) |-> $past(vec_req && vec_ack))
    else $error("R8 run without vector acknowledge");

endmodule

bind boot_seq_top boot_seq_chk #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/boot_seq_top_bench.sv
module boot_seq_top_bench;

  localparam int N_INIT = 8;
  localparam int INTV   = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        ref_req, ref_ack;
  logic        host_acc_ok;
  logic        vec_req, vec_ack;
  logic [31:0] vec_addr;
  logic        exec_go;
  logic [2:0]  boot_state;

  boot_seq_top #(.N_INIT(N_INIT), .REF_INTERVAL(INTV)) u_boot_seq_top (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ref_req(ref_req), .ref_ack(ref_ack), .host_acc_ok(host_acc_ok),
    .vec_req(vec_req), .vec_ack(vec_ack), .vec_addr(vec_addr),
    .exec_go(exec_go), .boot_state(boot_state)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Memory controller responders
  bit vec_en = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      ref_ack <= 1'b0;
      vec_ack <= 1'b0;
    end else begin
      ref_ack <= ref_req && !ref_ack;
      vec_ack <= vec_en && vec_req && !vec_ack;
    end
  end

  // Behavioural reference model, advanced at every rising edge
  int m_state, m_n, m_tmr;
  bit m_smp, m_mode, m_halt, m_pend, m_ok = 1'b0;

  always @(posedge clk) begin
    int s;
    bit hnew, ld;
    if (!rst_n) begin
      m_smp = host_sel; m_state = 0; m_mode = 0; m_halt = 0;
      m_n = 0; m_pend = 0; m_tmr = 0; m_ok = 1'b1;
    end else if (m_ok) begin
      s    = m_state;
      hnew = m_halt && !(ctl_we && !ctl_wdata[15]);
      ld   = 1'b0;
      if (s == 0) begin
        m_state = 1; m_mode = m_smp; hnew = m_smp;
      end else if (s == 1) begin
        if (ref_ack) begin
          m_n++;
          if (m_n == N_INIT) begin
            m_state = (m_mode && hnew) ? 2 : 3;
            ld = 1'b1;
          end
        end
      end else if (s == 2) begin
        if (!hnew) m_state = 3;
      end else if (s == 3) begin
        if (!m_pend && vec_ack) m_state = 4;
      end
      if (s >= 2 && m_pend && ref_ack) ld = 1'b1;
      if (ld) begin
        m_tmr = INTV - 1; m_pend = 0;
      end else if (s >= 2 && !m_pend) begin
        if (m_tmr == 0) m_pend = 1;
        else m_tmr--;
      end
      m_halt = hnew;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (m_ok) begin
      automatic bit e_vreq = (m_state == 3) && !m_pend;
      chk("R3 boot_state", boot_state, m_state);
      chk("R7 ref_req", ref_req, int'((m_state == 1) || m_pend));
      chk("R8 vec_req", vec_req, int'(e_vreq));
      chk("R8 vec_addr", int'(vec_addr == (e_vreq ? 32'hFFFF_FFE0 : 32'h0)), 1);
      chk("R4 host_acc_ok", host_acc_ok, int'(m_mode && m_state >= 2));
      chk("R8 exec_go", exec_go, int'(m_state == 4));
    end
  end

  // Event monitors
  int init_acks, ref_cnt, halt_vec, halt_visits;
  always @(posedge clk) begin
    if (rst_n) begin
      if (boot_state == 3'd1 && ref_ack) init_acks++;
      if (boot_state >= 3'd2 && ref_req && ref_ack) ref_cnt++;
      if (boot_state == 3'd2) halt_visits++;
      if (boot_state == 3'd2 && vec_req) halt_vec++;
    end
  end

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    host_sel = !mode;
    repeat (3) @(negedge clk);
    chk("R1 quiet outputs", int'({ref_req, vec_req, host_acc_ok, exec_go} == 4'b0 &&
                                 vec_addr == 32'h0 && boot_state == 3'd0), 1);
    host_sel = mode;
    @(negedge clk);
    rst_n = 1'b1;
    host_sel = !mode;
    init_acks = 0; ref_cnt = 0; halt_vec = 0; halt_visits = 0;
  endtask

  task automatic wait_state(int s, string tag);
    for (int i = 0; i < 2000; i++) begin
      if (boot_state == 3'(s)) break;
      @(negedge clk);
    end
    chk(tag, boot_state, s);
  endtask

  task automatic ctl_write(logic [15:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; ctl_we = 1'b0; ctl_wdata = 16'h0;

    // Host-present start
    do_reset(1'b1);
    wait_state(2, "R2 host mode reaches halted state R5");
    chk("R3 init acknowledges", init_acks, N_INIT);
    chk("R4 host access in host mode", host_acc_ok, 1);
    repeat (3 * INTV) @(negedge clk);
    chk("R7 refreshes while halted", int'(ref_cnt >= 2), 1);
    chk("R5 no vector request while halted", halt_vec, 0);
    ctl_write(16'h8000);
    repeat (2) @(negedge clk);
    chk("R5 write with halt bit set ignored", boot_state, 2);
    ctl_write(16'h0000);
    wait_state(4, "R8 run after vector fetch");
    chk("R8 exec_go in run", exec_go, 1);

    // Self-bootstrap start, with fetch stalled into a refresh
    vec_en = 1'b0;
    do_reset(1'b0);
    wait_state(3, "R9 self-boot straight to fetch");
    chk("R9 init acknowledges", init_acks, N_INIT);
    chk("R2 self mode never halted", halt_visits, 0);
    chk("R4 no host access in self mode", host_acc_ok, 0);
    chk("R8 vector request raised", vec_req, 1);
    for (int i = 0; i < 4 * INTV; i++) begin
      if (ref_req) break;
      @(negedge clk);
    end
    chk("R7 refresh pending during fetch", ref_req, 1);
    chk("R8 fetch yields to refresh", vec_req, 0);
    vec_en = 1'b1;
    wait_state(4, "R8 fetch completes after refresh");

    // Host mode with early halt clear, then reset from run
    do_reset(1'b1);
    wait_state(1, "R3 burst starts");
    ctl_write(16'h7FFF);
    wait_state(3, "R6 early clear skips halt");
    chk("R6 halted state never visited", halt_visits, 0);
    wait_state(4, "R6 run reached");
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R10 async return to reset", boot_state, 0);
    chk("R10 exec_go cleared", exec_go, 0);
    do_reset(1'b0);
    wait_state(3, "R10 sequence repeats");
    chk("R10 init acknowledges again", init_acks, N_INIT);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule